// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Engine

This block is the host end of a single pulled-up debug wire that no side ever drives high. It turns one upstream command into one timed event on the wire: a write slot for a 0 or a 1, a read slot whose value the target chooses, or the long low break that opens a session. The host paces every slot, including replies. The target only answers by stretching the low level after the host lets the line go.

A write slot pulls the line low for a fixed active time. It then leaves the line released for an idle time, and the length of that idle time carries the bit: the idle time is short for a 1 and long for a 0. A read slot pulls the line low briefly and then releases it. The block then counts, on the synchronized pin, how long the line stays low. A short hold decodes as 1 and a long hold as 0. If the hold exceeds a timeout, the slot ends with an error flag. The break holds the line low for a long time and then releases it for a short settling gap before the next slot. Every duration is a parameter counted in system clock cycles.

The upstream side issues a command while `busy` is low and waits for the one-cycle `done`. After a read, it takes `rdBit` and `timeoutErr` in the same cycle as `done`.

Top module: `dbgwire_host_phy`

## Requirements
- R1: Out of reset, `lineOe`, `busy` and `done` are all 0.
- R2: A command is accepted on a clock edge where `cmdValid` is 1 and `busy` is 0. The `cmdOp` codes are 2'b00 write 0, 2'b01 write 1, 2'b10 read and 2'b11 break. `busy` is 1 from the next cycle until the cycle in which `done` rises, and `busy` is 0 in that cycle.
- R3: A write slot holds `lineOe` at 1 for exactly ACT_CYC cycles, starting in the cycle after acceptance.
- R4: After the active phase, a write 0 keeps the line released for IDLE0_CYC cycles and a write 1 for IDLE1_CYC cycles. `done` pulses in the following cycle.
- R5: A read slot holds `lineOe` at 1 for exactly RD_DRV_CYC cycles and then releases the line. The hold time is measured on `lineIn` after a two-flop synchronizer.
- R6: A read whose release is seen with a hold count below RD_THR_CYC returns `rdBit`=1. A longer hold returns 0. `rdBit` is valid in the `done` cycle.
- R7: When a read sees the line go high, the slot ends RD_REC_CYC cycles later with `done`. The released time of the slot is therefore the target hold plus the synchronizer delay plus RD_REC_CYC.
- R8: If the line is still low RD_TMO_CYC cycles after release, the read ends at once with `done`=1, `timeoutErr`=1 and `rdBit`=0.
- R9: A break holds `lineOe` at 1 for BRK_CYC cycles, releases the line for BREL_CYC cycles, and then pulses `done`.
- R10: `cmdValid` while `busy` is 1 has no effect. The slot in progress keeps its timing and no extra `done` appears.
- R11: `lineOe` is 0 whenever `busy` is 0.
- R12: `done` lasts one cycle, and `timeoutErr` is never 1 outside a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | Command code (write 0, write 1, read, break) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command strobe |
| rdBit | output | 1 | Decoded read value, valid with done |
| timeoutErr | output | 1 | Read hold exceeded timeout, valid with done |
| lineOe | output | 1 | 1 pulls the wire low, 0 releases it |
| lineIn | input | 1 | Raw wire level |

## Verification
The assertions assume that `cmdValid` and `cmdOp` carry known values and that `lineIn` is never X after reset, because the wire model always resolves to a pulled-up or pulled-down level. They do not assume that the target releases in time, because the timeout path is part of the checked behaviour. The stimulus holds `cmdOp` steady while a request is pending. The modelled target lets the wire go only after the host has released it, and it keeps its hold lengths several cycles away from the decision threshold, except where a test aims at the threshold or the timeout on purpose.

// File: rtl/dbgwire_pkg.sv
package dbgwire_pkg;

  typedef enum logic [1:0] {
    OP_WR0   = 2'b00,
    OP_WR1   = 2'b01,
    OP_READ  = 2'b10,
    OP_BREAK = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    LIM_ACT, LIM_IDLE0, LIM_IDLE1, LIM_RDRV,
    LIM_TMO, LIM_REC, LIM_BRK, LIM_BREL
  } lim_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    lim_e limSel;
    logic capBit;
    logic capTmo;
    logic clrRes;
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dbgwire_sync.sv
module dbgwire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // reset to 1: the released wire idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dbgwire_datapath.sv
module dbgwire_datapath
  import dbgwire_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int ACT_CYC    = 50,
  parameter int IDLE0_CYC  = 200,
  parameter int IDLE1_CYC  = 50,
  parameter int RD_DRV_CYC = 20,
  parameter int RD_THR_CYC = 120,
  parameter int RD_TMO_CYC = 400,
  parameter int RD_REC_CYC = 40,
  parameter int BRK_CYC    = 400000,
  parameter int BREL_CYC   = 124
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    lineIn,
  output logic    lineHigh,
  output logic    cntDone,
  output logic    bitReg,
  output logic    tmoReg
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limVal;

  dbgwire_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .din(lineIn), .dout(lineHigh)
  );

  always_comb begin
    unique case (stb.limSel)
      LIM_ACT:   limVal = CNT_W'(ACT_CYC - 1);
      LIM_IDLE0: limVal = CNT_W'(IDLE0_CYC - 1);
      LIM_IDLE1: limVal = CNT_W'(IDLE1_CYC - 1);
      LIM_RDRV:  limVal = CNT_W'(RD_DRV_CYC - 1);
      LIM_TMO:   limVal = CNT_W'(RD_TMO_CYC - 1);
      LIM_REC:   limVal = CNT_W'(RD_REC_CYC - 1);
      LIM_BRK:   limVal = CNT_W'(BRK_CYC - 1);
      default:   limVal = CNT_W'(BREL_CYC - 1);
    endcase
  end

  assign cntDone = (cnt == limVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      bitReg <= 1'b0;
      tmoReg <= 1'b0;
    end else begin
      cnt <= stb.cntClr ? '0 : cnt + 1'b1;
      if (stb.clrRes) begin
        bitReg <= 1'b0;
        tmoReg <= 1'b0;
      end
      if (stb.capBit) bitReg <= (cnt < CNT_W'(RD_THR_CYC));
      if (stb.capTmo) tmoReg <= 1'b1;
    end
  end
endmodule

// File: rtl/dbgwire_ctrl.sv
module dbgwire_ctrl
  import dbgwire_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       lineHigh,
  input  logic       cntDone,
  output strobe_t    stb,
  output logic       lineOe,
  output logic       busy,
  output logic       done
);
  typedef enum logic [2:0] {
    S_IDLE, S_WACT, S_WIDLE, S_RDRV, S_RHOLD, S_RREC, S_BLOW, S_BREL
  } state_e;

  state_e state, stateNxt;
  logic   wrOne, wrOneNxt, doneNxt;

  always_comb begin
    stateNxt   = state;
    wrOneNxt   = wrOne;
    doneNxt    = 1'b0;
    stb        = '0;
    stb.limSel = LIM_ACT;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        stb.cntClr = 1'b1;
        stb.clrRes = 1'b1;
        unique case (op_e'(cmdOp))
          OP_WR0:   begin stateNxt = S_WACT; wrOneNxt = 1'b0; end
          OP_WR1:   begin stateNxt = S_WACT; wrOneNxt = 1'b1; end
          OP_READ:  stateNxt = S_RDRV;
          default:  stateNxt = S_BLOW;
        endcase
      end
      S_WACT: begin
        stb.limSel = LIM_ACT;
        if (cntDone) begin stateNxt = S_WIDLE; stb.cntClr = 1'b1; end
      end
      S_WIDLE: begin
        stb.limSel = wrOne ? LIM_IDLE1 : LIM_IDLE0;
        if (cntDone) begin stateNxt = S_IDLE; doneNxt = 1'b1; end
      end
      S_RDRV: begin
        stb.limSel = LIM_RDRV;
        if (cntDone) begin stateNxt = S_RHOLD; stb.cntClr = 1'b1; end
      end
      S_RHOLD: begin
        stb.limSel = LIM_TMO;
        if (lineHigh) begin
          stb.capBit = 1'b1;
          stb.cntClr = 1'b1;
          stateNxt   = S_RREC;
        end else if (cntDone) begin
          stb.capTmo = 1'b1;
          stateNxt   = S_IDLE;
          doneNxt    = 1'b1;
        end
      end
      S_RREC: begin
        stb.limSel = LIM_REC;
        if (cntDone) begin stateNxt = S_IDLE; doneNxt = 1'b1; end
      end
      S_BLOW: begin
        stb.limSel = LIM_BRK;
        if (cntDone) begin stateNxt = S_BREL; stb.cntClr = 1'b1; end
      end
      default: begin
        stb.limSel = LIM_BREL;
        if (cntDone) begin stateNxt = S_IDLE; doneNxt = 1'b1; end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      wrOne <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      wrOne <= wrOneNxt;
      done  <= doneNxt;
    end
  end

  assign lineOe = (state == S_WACT) || (state == S_RDRV) || (state == S_BLOW);
  assign busy   = (state != S_IDLE);
endmodule

// File: rtl/dbgwire_host_phy.sv
module dbgwire_host_phy
  import dbgwire_pkg::*;
#(
  parameter int ACT_CYC    = 50,
  parameter int IDLE0_CYC  = 200,
  parameter int IDLE1_CYC  = 50,
  parameter int RD_DRV_CYC = 20,
  parameter int RD_THR_CYC = 120,
  parameter int RD_TMO_CYC = 400,
  parameter int RD_REC_CYC = 40,
  parameter int BRK_CYC    = 400000,
  parameter int BREL_CYC   = 124
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output logic       busy,
  output logic       done,
  output logic       rdBit,
  output logic       timeoutErr,
  output logic       lineOe,
  input  logic       lineIn
);
  localparam int MAX_CYC = maxOf(maxOf(maxOf(ACT_CYC, IDLE0_CYC), maxOf(IDLE1_CYC, RD_DRV_CYC)),
                                 maxOf(maxOf(RD_TMO_CYC, RD_REC_CYC), maxOf(BRK_CYC, BREL_CYC)));
  localparam int CNT_W = $clog2(maxOf(MAX_CYC, RD_THR_CYC) + 1);

  strobe_t stb;
  logic    lineHigh, cntDone, bitReg, tmoReg;

  dbgwire_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .lineHigh(lineHigh), .cntDone(cntDone), .stb(stb),
    .lineOe(lineOe), .busy(busy), .done(done)
  );

  dbgwire_datapath #(
    .CNT_W(CNT_W), .ACT_CYC(ACT_CYC), .IDLE0_CYC(IDLE0_CYC), .IDLE1_CYC(IDLE1_CYC),
    .RD_DRV_CYC(RD_DRV_CYC), .RD_THR_CYC(RD_THR_CYC), .RD_TMO_CYC(RD_TMO_CYC),
    .RD_REC_CYC(RD_REC_CYC), .BRK_CYC(BRK_CYC), .BREL_CYC(BREL_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lineIn(lineIn),
    .lineHigh(lineHigh), .cntDone(cntDone), .bitReg(bitReg), .tmoReg(tmoReg)
  );

  assign rdBit      = bitReg;
  assign timeoutErr = done & tmoReg;
endmodule

// File: rtl/dbgwire_host_phy_chk.sv
module dbgwire_host_phy_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic busy,
  input logic done,
  input logic timeoutErr,
  input logic lineOe
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineOe);                                         // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy);                              // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                            // R12
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> done);                                       // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy && $past(busy)));                    // R4
endmodule

bind dbgwire_host_phy dbgwire_host_phy_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .busy(busy),
  .done(done), .timeoutErr(timeoutErr), .lineOe(lineOe)
);

// File: tb/dbgwire_host_phy_tb.sv
module dbgwire_host_phy_tb;
  localparam int ACT = 10, IDLE0 = 40, IDLE1 = 10, RDRV = 6, THR = 30;
  localparam int TMO = 80, REC = 8, BRK = 200, BREL = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic busy, done, rdBit, timeoutErr, lineOe, lineIn;

  always #2.5 clk = ~clk;  // 200 MHz

  // pulled-up wire: host or target may pull low
  logic tgtLow = 1'b0;
  logic tgtArmed = 1'b0;
  int   tgtHold = 0;
  int   relCnt = 0;
  assign lineIn = !(lineOe || tgtLow);

  dbgwire_host_phy #(
    .ACT_CYC(ACT), .IDLE0_CYC(IDLE0), .IDLE1_CYC(IDLE1), .RD_DRV_CYC(RDRV),
    .RD_THR_CYC(THR), .RD_TMO_CYC(TMO), .RD_REC_CYC(REC), .BRK_CYC(BRK), .BREL_CYC(BREL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .busy(busy),
    .done(done), .rdBit(rdBit), .timeoutErr(timeoutErr), .lineOe(lineOe), .lineIn(lineIn)
  );

  typedef struct packed {
    logic [15:0] oeCyc;
    logic [15:0] idleMin;
    logic [15:0] idleMax;
    logic        chkBit;
    logic        expBit;
    logic        expErr;
  } exp_t;

  exp_t expQ[$];
  int total = 0, bad = 0, pushed = 0, seen = 0;
  int oeCnt = 0, idleCnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // target model: after the host releases in a read, hold low for tgtHold cycles
  always @(negedge clk) begin
    if (tgtArmed && busy && !lineOe) begin
      tgtLow <= (relCnt < tgtHold);
      relCnt <= relCnt + 1;
    end else if (!busy) begin
      tgtLow <= 1'b0;
      relCnt <= 0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        if (lineOe) oeCnt++;
        else        idleCnt++;
      end
      if (done) begin
        seen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected done", seen, pushed);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(oeCnt == int'(e.oeCyc), "R3/R5/R9 drive length", oeCnt, int'(e.oeCyc));
          check(idleCnt >= int'(e.idleMin) && idleCnt <= int'(e.idleMax),
                "R4/R7/R9 released length", idleCnt, int'(e.idleMin));
          check(busy == 1'b0, "R2 busy low at done", int'(busy), 0);
          check(timeoutErr == e.expErr, "R8 timeout flag", int'(timeoutErr), int'(e.expErr));
          if (e.chkBit) check(rdBit == e.expBit, "R6 read value", int'(rdBit), int'(e.expBit));
        end
        oeCnt = 0;
        idleCnt = 0;
      end
    end
  end

  task automatic sendCmd(input logic [1:0] op, input exp_t e, input int hold);
    while (busy) @(negedge clk);
    tgtArmed = (op == 2'b10);
    tgtHold  = hold;
    expQ.push_back(e);
    pushed++;
    cmdValid = 1'b1;
    cmdOp    = op;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic exp_t mk(input int oe, input int mn, input int mx,
                              input logic cb, input logic b, input logic er);
    exp_t e;
    e.oeCyc = 16'(oe); e.idleMin = 16'(mn); e.idleMax = 16'(mx);
    e.chkBit = cb; e.expBit = b; e.expErr = er;
    return e;
  endfunction

  function automatic exp_t rdExp(input int h, input logic b);
    return mk(RDRV, h + 2 + REC, h + 4 + REC, 1'b1, b, 1'b0);
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lineOe == 1'b0, "R1 lineOe reset", int'(lineOe), 0);
    check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    check(done == 1'b0, "R1 done reset", int'(done), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(lineOe == 1'b0, "R11 released when idle", int'(lineOe), 0);

    sendCmd(2'b00, mk(ACT, IDLE0, IDLE0, 1'b0, 1'b0, 1'b0), 0);   // R3 R4 write 0
    sendCmd(2'b01, mk(ACT, IDLE1, IDLE1, 1'b0, 1'b0, 1'b0), 0);   // R3 R4 write 1
    sendCmd(2'b11, mk(BRK, BREL, BREL, 1'b0, 1'b0, 1'b0), 0);     // R9 break
    sendCmd(2'b10, rdExp(5, 1'b1), 5);                            // R5 R6 R7 short hold
    sendCmd(2'b10, rdExp(50, 1'b0), 50);                          // R6 long hold
    sendCmd(2'b10, rdExp(THR - 8, 1'b1), THR - 8);                // R6 below threshold
    sendCmd(2'b10, rdExp(THR + 3, 1'b0), THR + 3);                // R6 above threshold
    sendCmd(2'b10, mk(RDRV, TMO, TMO, 1'b1, 1'b0, 1'b1), 1000);   // R8 timeout

    // R10: requests during a busy write 0 are ignored
    while (busy) @(negedge clk);
    tgtArmed = 1'b0;
    expQ.push_back(mk(ACT, IDLE0, IDLE0, 1'b0, 1'b0, 1'b0));
    pushed++;
    cmdValid = 1'b1; cmdOp = 2'b00;
    @(negedge clk);
    cmdOp = 2'b11;
    repeat (20) @(negedge clk);
    cmdValid = 1'b0;
    while (!done) @(negedge clk);
    repeat (30) @(negedge clk);
    check(busy == 1'b0, "R10 no extra command", int'(busy), 0);
    check(seen == pushed, "R10 done count", seen, pushed);
    check(expQ.size() == 0, "R12 all results seen", expQ.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule